// File: doc/BRIEF.md
# Command Mailbox Register Block

This block gives a host a small memory-mapped window for handing a command to a device and collecting a return code. The host reaches it through a plain register bus that carries one 4-byte or 8-byte little-endian access per cycle. It first writes a 64-bit command word: an opcode, a command-set selector and an input length. It then sets a doorbell bit in the control word and polls that bit. While the doorbell is set, a sequencer inside the block handles the command. It posts a 16-bit return code into the status register, then rewrites the command word so that the opcode and set fields are zero and the length field holds the output length. Last, it drops the doorbell.

No command set has a handler here, so every command is answered with the code for "unsupported" (0x3). The other codes the block knows are success 0x0, invalid input 0x2, busy 0x6 and invalid payload length 0x16. The capability word reports a payload size exponent of 11, which means 2048 bytes, and it advertises neither interrupts nor background commands.

The sequencer has five states:
- IDLE waits for the doorbell and moves to DECODE.
- DECODE latches the return code for the command set and moves to POST_STATUS.
- POST_STATUS writes the status register and moves to REWRITE_CMD.
- REWRITE_CMD clears the opcode and set fields, loads the output length, and moves to RELEASE.
- RELEASE clears the doorbell and returns to IDLE.

Top module: `mbox_regblk`

## Requirements
- R1: After reset, a 4-byte read at 0x0 returns 0x0000000B. Reads of control (0x4), command (0x8) and status (0x10) return zero.
- R2: Only accesses of size 4 or 8 bytes are legal. A read of any other size returns zero, and a write of any other size changes nothing.
- R3: A 4-byte access must be 4-byte aligned and an 8-byte access must be 8-byte aligned. A misaligned read returns zero and a misaligned write is dropped.
- R4: The register map has five slots. The capability word is at 0x0 (bits 4:0 hold the size exponent). Control is at 0x4, command at 0x8 (64-bit), status at 0x10 (64-bit) and background status at 0x18 (64-bit, always zero). An 8-byte read at 0x0 returns control in bits 63:32 and capability in bits 31:0. A 4-byte read at offset+4 returns the upper half of an 8-byte slot. Any offset at 0x20 or above reads zero.
- R5: The capability word, the status register and the background status register ignore every host write.
- R6: The command register is loaded only by an 8-byte write at 0x8, and a 4-byte write to 0x8 or 0xC is ignored. Its fields are the opcode in bits 7:0, the command set in bits 15:8 and the length in bits 35:16.
- R7: A 4-byte write at 0x4 with bit 0 set raises the doorbell. Writing 0 to bit 0 never clears it. All other control bits read as zero, including bit 2, the background-interrupt enable.
- R8: On completion, status bits 47:32 hold the return code and all other status bits are zero. Command bits 35:0 read zero, the output length being 0, and command bits 63:36 keep their value.
- R9: The doorbell reads 1 for exactly 5 cycles after the write that sets it. The status and command updates are visible no later than the cycle in which it reads 0.
- R10: While the doorbell is set, host writes to the command register are ignored.
- R11: Every command set, including 0x00 and 0xFF, completes with return code 0x0003.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the window |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, little-endian, low bytes used for 4-byte writes |
| rsp_rdata | output | 64 | Read data, same cycle as the request; upper half zero for 4-byte reads |

## Verification
The hardest situation to create from the ports is a host write that lands while a command is in flight. The doorbell is only up for a few cycles, and only a write issued within that window exercises the busy guard. The bench rings the doorbell and, in the very next bus slot, issues an 8-byte command write with different data. In a separate run it issues a write of 0 to the doorbell in the same window and reads the doorbell back while the command is still in flight. The final command value shows whether the command write was kept out, and the read-back shows whether the zero write was ignored.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // byte offsets of the register slots
    localparam int OFS_CAP      = 'h00;
    localparam int OFS_CTRL     = 'h04;
    localparam int OFS_CMD      = 'h08;
    localparam int OFS_STS      = 'h10;
    localparam int OFS_BGSTS    = 'h18;
    localparam int WINDOW_BYTES = 'h20;
    localparam int NUM_SLOTS    = WINDOW_BYTES / 8;

    // command word field layout
    localparam int CMD_LEN_LO = 16;
    localparam int CMD_LEN_W  = 20;
    localparam int CMD_KEEP_LO = CMD_LEN_LO + CMD_LEN_W;

    // status word field layout
    localparam int STS_RC_LO = 32;
    localparam int STS_RC_W  = 16;

    typedef enum logic [15:0] {
        RC_SUCCESS     = 16'h0000,
        RC_BAD_INPUT   = 16'h0002,
        RC_UNSUPPORTED = 16'h0003,
        RC_BUSY        = 16'h0006,
        RC_BAD_LENGTH  = 16'h0016
    } ret_code_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DECODE,
        SQ_POST_STATUS,
        SQ_REWRITE_CMD,
        SQ_RELEASE
    } seq_state_e;

    // no command set has a handler: every selector maps to unsupported
    function automatic ret_code_e rc_for_set(input logic [7:0] set_sel);
        ret_code_e rc;
        case (set_sel)
            default: rc = RC_UNSUPPORTED;
        endcase
        return rc;
    endfunction

endpackage

// File: rtl/mbox_acc_decode.sv
module mbox_acc_decode
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    output logic              rd_ok,
    output logic              rd_wide,
    output logic [1:0]        rd_slot,
    output logic              rd_upper,
    output logic              wr_ctrl,
    output logic              wr_cmd
);

    localparam logic [ADDR_W-1:0] WIN_LIMIT = ADDR_W'(WINDOW_BYTES);

    logic size4, size8, in_win, legal;

    always_comb begin
        size4  = (req_size == 4'd4) && (req_addr[1:0] == 2'b00);
        size8  = (req_size == 4'd8) && (req_addr[2:0] == 3'b000);
        in_win = req_addr < WIN_LIMIT;
        legal  = req_valid && in_win && (size4 || size8);

        rd_ok    = legal && !req_write;
        rd_wide  = size8;
        rd_slot  = req_addr[4:3];
        rd_upper = req_addr[2];

        wr_ctrl = legal && req_write && size4 && (req_addr[4:2] == 3'(OFS_CTRL / 4));
        wr_cmd  = legal && req_write && size8 && (req_addr[4:3] == 2'(OFS_CMD / 8));
    end

endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
    import mbox_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        doorbell,
    input  logic [7:0]  cmd_set,
    output logic [15:0] ret_code,
    output logic        post_status,
    output logic        rewrite_cmd,
    output logic        release_db
);

    seq_state_e state_q, state_d;
    ret_code_e  rc_q;

    // state register and latched return code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            rc_q    <= RC_SUCCESS;
        end else begin
            state_q <= state_d;
            if (state_q == SQ_DECODE) begin
                rc_q <= rc_for_set(cmd_set);
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        post_status = 1'b0;
        rewrite_cmd = 1'b0;
        release_db  = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (doorbell) state_d = SQ_DECODE;
            end
            SQ_DECODE: begin
                state_d = SQ_POST_STATUS;
            end
            SQ_POST_STATUS: begin
                post_status = 1'b1;
                state_d     = SQ_REWRITE_CMD;
            end
            SQ_REWRITE_CMD: begin
                rewrite_cmd = 1'b1;
                state_d     = SQ_RELEASE;
            end
            SQ_RELEASE: begin
                release_db = 1'b1;
                state_d    = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    assign ret_code = rc_q;

endmodule

// File: rtl/mbox_regblk.sv
module mbox_regblk
    import mbox_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAYLOAD_EXP = 11,
    parameter int OUT_LEN     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic [63:0]       rsp_rdata
);

    localparam logic [31:0] CAP_WORD = 32'(PAYLOAD_EXP & 'h1F);

    logic        db_q;
    logic [63:0] cmd_q;
    logic [63:0] sts_q;

    logic        rd_ok, rd_wide, rd_upper, wr_ctrl, wr_cmd;
    logic [1:0]  rd_slot;
    logic [15:0] ret_code;
    logic        post_status, rewrite_cmd, release_db;

    mbox_acc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .rd_ok     (rd_ok),
        .rd_wide   (rd_wide),
        .rd_slot   (rd_slot),
        .rd_upper  (rd_upper),
        .wr_ctrl   (wr_ctrl),
        .wr_cmd    (wr_cmd)
    );

    mbox_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .doorbell    (db_q),
        .cmd_set     (cmd_q[15:8]),
        .ret_code    (ret_code),
        .post_status (post_status),
        .rewrite_cmd (rewrite_cmd),
        .release_db  (release_db)
    );

    // doorbell: host may only set it, the sequencer clears it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_q <= 1'b0;
        end else if (release_db) begin
            db_q <= 1'b0;
        end else if (wr_ctrl && req_wdata[0]) begin
            db_q <= 1'b1;
        end
    end

    // command word: host load only while idle, sequencer rewrite on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (rewrite_cmd) begin
            cmd_q <= {cmd_q[63:CMD_KEEP_LO], CMD_LEN_W'(OUT_LEN), 16'h0000};
        end else if (wr_cmd && !db_q) begin
            cmd_q <= req_wdata;
        end
    end

    // status word: sequencer only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else if (post_status) begin
            sts_q <= 64'(ret_code) << STS_RC_LO;
        end
    end

    // read path: one 64-bit image per slot
    logic [63:0] slot_img [NUM_SLOTS];
    logic [63:0] sel_img;

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            if (s == OFS_CAP / 8) begin : g_capctl
                assign slot_img[s] = {31'b0, db_q, CAP_WORD};
            end else if (s == OFS_CMD / 8) begin : g_cmd
                assign slot_img[s] = cmd_q;
            end else if (s == OFS_STS / 8) begin : g_sts
                assign slot_img[s] = sts_q;
            end else begin : g_zero
                assign slot_img[s] = '0;
            end
        end
    endgenerate

    always_comb begin
        sel_img = slot_img[rd_slot];
        if (!rd_ok) begin
            rsp_rdata = '0;
        end else if (rd_wide) begin
            rsp_rdata = sel_img;
        end else begin
            rsp_rdata = {32'b0, rd_upper ? sel_img[63:32] : sel_img[31:0]};
        end
    end

endmodule

// File: rtl/mbox_regblk_chk.sv
module mbox_regblk_chk #(
    parameter int ADDR_W   = 8,
    parameter int MAX_BUSY = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_size,
    input logic [63:0]       rsp_rdata,
    input logic              doorbell,
    input logic [63:0]       cmd,
    input logic [63:0]       sts
);

    logic [3:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)        busy_cnt <= '0;
        else if (doorbell) busy_cnt <= busy_cnt + 4'd1;
        else               busy_cnt <= '0;
    end

    // R9
    db_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= 4'(MAX_BUSY));

    // R8
    completion_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(doorbell) |-> (sts[47:32] == 16'h0003) && (cmd[35:0] == 36'h0));

    // R5
    sts_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sts) |-> $past(doorbell));

    // R10
    busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(doorbell) && !$stable(cmd)) |-> (cmd[35:0] == 36'h0));

    // R3
    misalign_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 4'd4 && req_addr[1:0] != 2'b00)
        |-> (rsp_rdata == 64'h0));

    // R2
    bad_size_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size != 4'd4 && req_size != 4'd8)
        |-> (rsp_rdata == 64'h0));

    // R1
    cap_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 4'd4 && req_addr == '0)
        |-> (rsp_rdata == 64'h0B));

endmodule

bind mbox_regblk mbox_regblk_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_rdata (rsp_rdata),
    .doorbell  (db_q),
    .cmd       (cmd_q),
    .sts       (sts_q)
);

// File: tb/mbox_regblk_tb.sv
module mbox_regblk_tb;

    localparam int ADDR_W = 8;
    localparam int BUSY_CYCLES = 5;
    localparam logic [63:0] CW = 64'hABCD_1234_0005_0301;
    localparam logic [63:0] FF = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic        wr;
        logic [3:0]  sz;
        logic [7:0]  addr;
        logic [63:0] data;
        logic [63:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'd4, 8'h00, 64'h0, 64'h0B, 8'd1},   // R1 capability
        '{1'b0, 4'd4, 8'h04, 64'h0, 64'h0,  8'd1},   // R1 control
        '{1'b0, 4'd8, 8'h08, 64'h0, 64'h0,  8'd1},   // R1 command
        '{1'b0, 4'd8, 8'h10, 64'h0, 64'h0,  8'd1},   // R1 status
        '{1'b1, 4'd8, 8'h08, CW,    64'h0,  8'd6},   // R6 load command
        '{1'b0, 4'd8, 8'h08, 64'h0, CW,     8'd6},   // R6
        '{1'b0, 4'd4, 8'h08, 64'h0, 64'h0005_0301, 8'd4}, // R4 low half
        '{1'b0, 4'd4, 8'h0C, 64'h0, 64'hABCD_1234, 8'd4}, // R4 high half
        '{1'b1, 4'd4, 8'h08, FF,    64'h0,  8'd6},   // R6 narrow write ignored
        '{1'b0, 4'd8, 8'h08, 64'h0, CW,     8'd6},   // R6
        '{1'b1, 4'd8, 8'h10, FF,    64'h0,  8'd5},   // R5 status write
        '{1'b0, 4'd8, 8'h10, 64'h0, 64'h0,  8'd5},   // R5
        '{1'b1, 4'd8, 8'h18, FF,    64'h0,  8'd5},   // R5 bg status write
        '{1'b0, 4'd8, 8'h18, 64'h0, 64'h0,  8'd5},   // R5
        '{1'b1, 4'd4, 8'h00, FF,    64'h0,  8'd5},   // R5 capability write
        '{1'b0, 4'd4, 8'h00, 64'h0, 64'h0B, 8'd5},   // R5
        '{1'b0, 4'd2, 8'h00, 64'h0, 64'h0,  8'd2},   // R2 2-byte read
        '{1'b0, 4'd1, 8'h08, 64'h0, 64'h0,  8'd2},   // R2 1-byte read
        '{1'b1, 4'd2, 8'h08, 64'h0, 64'h0,  8'd2},   // R2 2-byte write
        '{1'b0, 4'd8, 8'h08, 64'h0, CW,     8'd2},   // R2
        '{1'b0, 4'd4, 8'h02, 64'h0, 64'h0,  8'd3},   // R3 misaligned 4B read
        '{1'b0, 4'd8, 8'h04, 64'h0, 64'h0,  8'd3},   // R3 misaligned 8B read
        '{1'b1, 4'd8, 8'h04, FF,    64'h0,  8'd3},   // R3 misaligned 8B write
        '{1'b0, 4'd4, 8'h04, 64'h0, 64'h0,  8'd3},   // R3 doorbell untouched
        '{1'b1, 4'd8, 8'h0C, 64'h0, 64'h0,  8'd3},   // R3 misaligned cmd write
        '{1'b0, 4'd8, 8'h08, 64'h0, CW,     8'd3},   // R3
        '{1'b0, 4'd8, 8'h00, 64'h0, 64'h0B, 8'd4},   // R4 combined slot 0
        '{1'b0, 4'd4, 8'h20, 64'h0, 64'h0,  8'd4},   // R4 outside window
        '{1'b1, 4'd4, 8'h04, 64'hFFFF_FFFE, 64'h0, 8'd7}, // R7 other ctrl bits
        '{1'b0, 4'd4, 8'h04, 64'h0, 64'h0,  8'd7},   // R7
        '{1'b0, 4'd4, 8'h14, 64'h0, 64'h0,  8'd4}    // R4 status upper half
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        req_size = '0;
    logic [63:0]       req_wdata = '0;
    logic [63:0]       rsp_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mbox_regblk #(.ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] sz, input logic [7:0] addr, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_size = sz; req_addr = addr; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] sz, input logic [7:0] addr, output logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size = sz; req_addr = addr;
        #1 d = rsp_rdata;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // called right after the doorbell write returns; counts cycles with doorbell at 1
    task automatic wait_done(output int n);
        n = 0;
        req_valid = 1'b1; req_write = 1'b0; req_size = 4'd4; req_addr = 8'h04;
        #1;
        while (rsp_rdata[0] && n < 50) begin
            n++;
            @(negedge clk);
            #1;
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R9: watchdog expired, actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        int busy;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                do_write(VEC[i].sz, VEC[i].addr, VEC[i].data);
            end else begin
                do_read(VEC[i].sz, VEC[i].addr, rd);
                check(rd, VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
            end
        end

        // R9 latency, R8 completion image, R11 return code
        do_write(4'd8, 8'h08, 64'h1234_5678_9ABC_0201);
        do_write(4'd4, 8'h04, 64'h1);
        wait_done(busy);
        check(64'(busy), 64'(BUSY_CYCLES), "R9 doorbell busy cycles");
        do_read(4'd8, 8'h08, rd);
        check(rd, 64'h1234_5670_0000_0000, "R8 command rewritten");
        do_read(4'd8, 8'h10, rd);
        check(rd, 64'h0000_0003_0000_0000, "R8 R11 status word");

        // R10: command write while busy is ignored
        do_write(4'd8, 8'h08, 64'hFFFF_FFF0_0000_0A05);
        do_write(4'd4, 8'h04, 64'h1);
        do_write(4'd8, 8'h08, 64'h0);
        wait_done(busy);
        do_read(4'd8, 8'h08, rd);
        check(rd, 64'hFFFF_FFF0_0000_0000, "R10 command kept during busy");

        // R7: writing 0 to the doorbell does not clear it
        do_write(4'd4, 8'h04, 64'h1);
        do_write(4'd4, 8'h04, 64'h0);
        do_read(4'd4, 8'h04, rd);
        check(rd, 64'h1, "R7 doorbell held after zero write");
        wait_done(busy);
        do_read(4'd4, 8'h04, rd);
        check(rd, 64'h0, "R7 doorbell cleared by sequencer");

        // R11: set 0x00 and 0xFF
        do_write(4'd8, 8'h08, 64'h0000_0000_0000_0000);
        do_write(4'd4, 8'h04, 64'h1);
        wait_done(busy);
        do_read(4'd4, 8'h14, rd);
        check(rd, 64'h3, "R11 set 0x00");
        do_write(4'd8, 8'h08, 64'h0000_0000_0000_FF7E);
        do_write(4'd4, 8'h04, 64'h1);
        wait_done(busy);
        check(64'(busy), 64'(BUSY_CYCLES), "R9 second run busy cycles");
        do_read(4'd4, 8'h14, rd);
        check(rd, 64'h3, "R11 set 0xFF");
        do_read(4'd4, 8'h08, rd);
        check(rd, 64'h0, "R8 opcode and set cleared");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule